// File: doc/BRIEF.md
# Symmetric-Offset Segmented DAC Decoder

This block turns each 16-bit two's complement audio sample into the switch controls of a segmented current-steering converter. The coarse section is a bank of 32 equal unit sources, each switched on by one bit of a thermometer vector. A further unit source feeds an 11-bit binary divider, and the 11-bit fine code selects which divider currents reach the output. The analog sum of the enabled units plus the selected divider fraction forms the converter output.

The sample is first moved into offset-binary form by flipping its sign bit. It is then shifted up by half a coarse unit (1024 fine steps). This places the bipolar zero, sample 0000h, in the middle of a coarse segment rather than on a segment boundary. As a result, stepping between FFFFh and 0000h moves only the fine code, and the coarse sources stay untouched. That is why the converter shows no glitch at zero crossing. All controls are registered together on a load strobe, so the switch pattern never mixes two samples.

Top module: `symoff_dac_decoder`

## Requirements
- R1: While `rst_n` is low, `unit_en`, `fine_code` and `div_en` are all zero.
- R2: Outputs take the new sample's pattern on the first rising clock edge at which `load` is high, and not before that edge.
- R3: `unit_en` is a thermometer vector: bits 0 to k-1 are set and all others are clear. k = floor((U + 1024) / 2048), where U is the sample with bit 15 inverted, read as unsigned. k ranges from 0 to 32.
- R4: `fine_code` equals (U + 1024) mod 2048, which is U[10:0] with bit 10 inverted.
- R5: `div_en` is high after any load that follows reset.
- R6: Samples FFFFh and 0000h give the same `unit_en`, which is the lower 16 sources. Their fine codes are 3FFh and 400h, so only the fine controls differ.
- R7: Sample 8000h enables no unit source, with fine code 400h. Sample 7FFFh enables all 32 unit sources, with fine code 3FFh.
- R8: For every loaded sample, the number of set `unit_en` bits times 2048, plus `fine_code`, equals U + 1024. The output is therefore linear and monotonic in the sample.
- R9: A change on `sample` while `load` is low leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Strobe: capture and decode `sample` at this edge |
| sample | input | 16 | Two's complement input sample |
| unit_en | output | 32 | Thermometer enables for the coarse unit sources |
| div_en | output | 1 | Routes the divider's unit source to the output |
| fine_code | output | 11 | Binary divider bit selection |

## Verification
A coarse update and a fine update can land in the same capture edge. The sharpest case is back-to-back loads that cross zero or a segment boundary, where one edge changes only fine bits and the next changes the unit count as well. The bench provokes this with loads on consecutive cycles: FFFFh then 0000h, then 03FFh then 0400h. After each edge it judges whether the unit vector stayed put or advanced by exactly one source, and checks that the sum of sources and fine code still tracks the sample. A load issued on the first cycle after reset release is also checked, so that it is captured whole.

// File: rtl/symoff_pkg.sv
package symoff_pkg;
    localparam int DEF_DATA_W = 16;
    localparam int DEF_FINE_W = 11;
endpackage

// File: rtl/sd_offset_map.sv
module sd_offset_map #(
    parameter int DATA_W = 16,
    parameter int FINE_W = 11,
    localparam int COARSE_W = DATA_W - FINE_W,
    localparam int CNT_W = COARSE_W + 1
) (
    input  logic [DATA_W-1:0] sample,
    output logic [CNT_W-1:0]  unit_count,
    output logic [FINE_W-1:0] fine
);
    logic [DATA_W-1:0] ofs_bin;
    logic              half;

    always_comb begin
        ofs_bin    = {~sample[DATA_W-1], sample[DATA_W-2:0]};
        half       = ofs_bin[FINE_W-1];
        // adding half a coarse unit: carry from bit FINE_W-1 lands in the count
        unit_count = {1'b0, ofs_bin[DATA_W-1:FINE_W]} + CNT_W'(half);
        fine       = {~half, ofs_bin[FINE_W-2:0]};
    end
endmodule

// File: rtl/sd_therm.sv
module sd_therm #(
    parameter int UNITS = 32,
    parameter int CNT_W = 6
) (
    input  logic [CNT_W-1:0] unit_count,
    output logic [UNITS-1:0] therm
);
    for (genvar i = 0; i < UNITS; i++) begin : g_unit
        assign therm[i] = (unit_count > CNT_W'(i));
    end
endmodule

// File: rtl/symoff_dac_decoder.sv
module symoff_dac_decoder #(
    parameter int DATA_W = symoff_pkg::DEF_DATA_W,
    parameter int FINE_W = symoff_pkg::DEF_FINE_W,
    localparam int COARSE_W = DATA_W - FINE_W,
    localparam int UNITS = 1 << COARSE_W,
    localparam int CNT_W = COARSE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] sample,
    output logic [UNITS-1:0]  unit_en,
    output logic              div_en,
    output logic [FINE_W-1:0] fine_code
);
    typedef struct packed {
        logic [UNITS-1:0]  units;
        logic              div;
        logic [FINE_W-1:0] fine;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [CNT_W-1:0]  cnt_w;
    logic [FINE_W-1:0] fine_w;
    logic [UNITS-1:0]  therm_w;

    sd_offset_map #(.DATA_W(DATA_W), .FINE_W(FINE_W)) u_map (
        .sample     (sample),
        .unit_count (cnt_w),
        .fine       (fine_w)
    );

    sd_therm #(.UNITS(UNITS), .CNT_W(CNT_W)) u_therm (
        .unit_count (cnt_w),
        .therm      (therm_w)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (load) begin
            ctl_d.units = therm_w;
            ctl_d.div   = 1'b1;
            ctl_d.fine  = fine_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign unit_en   = ctl_q.units;
    assign div_en    = ctl_q.div;
    assign fine_code = ctl_q.fine;
endmodule

// File: rtl/sd_checker.sv
module sd_checker #(
    parameter int DATA_W = 16,
    parameter int FINE_W = 11,
    parameter int UNITS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load,
    input logic [DATA_W-1:0] sample,
    input logic [UNITS-1:0]  unit_en,
    input logic              div_en,
    input logic [FINE_W-1:0] fine_code
);
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (unit_en == '0 && fine_code == '0 && !div_en));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(unit_en) && $stable(fine_code) && $stable(div_en)));

    p_therm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((({1'b0, unit_en} + 1'b1) & {1'b0, unit_en}) == '0));

    p_linear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ((($countones(unit_en)) << FINE_W) + int'(fine_code)
                  == int'({~$past(sample[DATA_W-1]), $past(sample[DATA_W-2:0])})
                     + (1 << (FINE_W-1))));

    p_div_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> div_en);

    p_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (sample == '0 || sample == '1)) |=> ($countones(unit_en) == UNITS/2));
endmodule

bind symoff_dac_decoder sd_checker #(
    .DATA_W(DATA_W), .FINE_W(FINE_W), .UNITS(UNITS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .load(load), .sample(sample),
    .unit_en(unit_en), .div_en(div_en), .fine_code(fine_code)
);

// File: tb/sim_symoff_dac_decoder.sv
module sim_symoff_dac_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [15:0] sample = '0;
    logic [31:0] unit_en;
    logic        div_en;
    logic [10:0] fine_code;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    symoff_dac_decoder u0 (
        .clk(clk), .rst_n(rst_n), .load(load), .sample(sample),
        .unit_en(unit_en), .div_en(div_en), .fine_code(fine_code)
    );

    // {sample, expected unit count, expected fine code}
    localparam int NV = 14;
    localparam logic [32:0] TBL [NV] = '{
        {16'h0000, 6'd16, 11'h400},
        {16'hFFFF, 6'd16, 11'h3FF},
        {16'h8000, 6'd0,  11'h400},
        {16'h7FFF, 6'd32, 11'h3FF},
        {16'h0001, 6'd16, 11'h401},
        {16'hFFFE, 6'd16, 11'h3FE},
        {16'h0400, 6'd17, 11'h000},
        {16'h03FF, 6'd16, 11'h7FF},
        {16'h1234, 6'd18, 11'h634},
        {16'hC000, 6'd8,  11'h400},
        {16'h7C00, 6'd32, 11'h000},
        {16'h7BFF, 6'd31, 11'h7FF},
        {16'h83FF, 6'd0,  11'h7FF},
        {16'h8400, 6'd1,  11'h000}
    };

    function automatic logic [31:0] therm_of(input int k);
        logic [32:0] w;
        w = (33'd1 << k) - 33'd1;
        return w[31:0];
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [15:0] s);
        @(negedge clk);
        sample = s;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] hold_u;
        logic [10:0] hold_f;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 unit_en", 64'(unit_en), 64'h0);
        chk("R1 fine_code", 64'(fine_code), 64'h0);
        chk("R1 div_en", 64'(div_en), 64'h0);
        rst_n = 1'b1;

        // load on the first cycle after reset release
        do_load(16'h1234);
        chk("R5 div_en after first load", 64'(div_en), 64'h1);
        chk("R3 first load units", 64'(unit_en), 64'(therm_of(18)));

        for (int i = 0; i < NV; i++) begin
            logic [15:0] s;
            int          k;
            logic [10:0] f;
            int          u;
            s = TBL[i][32:17];
            k = int'(TBL[i][16:11]);
            f = TBL[i][10:0];
            do_load(s);
            chk($sformatf("R3 units for %h", s), 64'(unit_en), 64'(therm_of(k)));
            chk($sformatf("R4 fine for %h", s), 64'(fine_code), 64'(f));
            u = int'({~s[15], s[14:0]}) + 1024;
            chk($sformatf("R8 sum for %h", s),
                64'($countones(unit_en) * 2048 + int'(fine_code)), 64'(u));
        end

        // R7 endpoints
        do_load(16'h8000);
        chk("R7 min units", 64'(unit_en), 64'h0);
        chk("R7 min fine", 64'(fine_code), 64'h400);
        do_load(16'h7FFF);
        chk("R7 max units", 64'(unit_en), 64'hFFFF_FFFF);
        chk("R7 max fine", 64'(fine_code), 64'h3FF);

        // R6 back-to-back loads across zero
        @(negedge clk);
        sample = 16'hFFFF;
        load = 1'b1;
        @(negedge clk);
        hold_u = unit_en;
        chk("R6 fine at FFFF", 64'(fine_code), 64'h3FF);
        sample = 16'h0000;
        @(negedge clk);
        load = 1'b0;
        chk("R6 units unchanged across zero", 64'(unit_en), 64'(hold_u));
        chk("R6 units lower half", 64'(unit_en), 64'h0000_FFFF);
        chk("R6 fine at 0000", 64'(fine_code), 64'h400);

        // back-to-back across a segment boundary
        @(negedge clk);
        sample = 16'h03FF;
        load = 1'b1;
        @(negedge clk);
        sample = 16'h0400;
        @(negedge clk);
        load = 1'b0;
        chk("R3 boundary step one unit", 64'(unit_en), 64'(therm_of(17)));
        chk("R4 boundary fine", 64'(fine_code), 64'h0);

        // R2: new pattern not visible before the capture edge
        @(negedge clk);
        hold_u = unit_en;
        hold_f = fine_code;
        sample = 16'h8000;
        load = 1'b1;
        @(posedge clk);
        #1;
        load = 1'b0;
        chk("R2 units after edge", 64'(unit_en), 64'h0);
        chk("R2 fine after edge", 64'(fine_code), 64'h400);

        // R9: sample changes without load are ignored
        @(negedge clk);
        hold_u = unit_en;
        hold_f = fine_code;
        sample = 16'h7FFF;
        repeat (2) @(negedge clk);
        sample = 16'h1234;
        repeat (2) @(negedge clk);
        chk("R9 units held", 64'(unit_en), 64'(hold_u));
        chk("R9 fine held", 64'(fine_code), 64'(hold_f));
        chk("R9 div held", 64'(div_en), 64'h1);

        // R1 again: reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 units after reset", 64'(unit_en), 64'h0);
        chk("R1 div after reset", 64'(div_en), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule